// File: doc/BRIEF.md
# Encoded SPI Bit-Clock Scaler

This block derives the serial bit clock for a synchronous serial port from the module clock. Each channel holds a 16-bit scale word written over a simple register-write port. The word does not hold a count. It packs two fields. The low three bits are an exponent code, and a five-bit field higher up switches in a fixed divide-by-32 prescaler. Together they select a total divide of 1, 2, 4, up to 1024 module clocks per SCK period.

Every channel drives an SCK line with a selectable idle level. It also raises two one-cycle strobes: one on the cycle SCK leaves its idle level (leading edge) and one on the cycle it returns (trailing edge). A shift engine uses these strobes to launch and capture data. A channel runs only while its enable input is high. While the enable is low, SCK sits at idle and the counters are cleared. A scale word written while the channel runs is held back. It takes effect at the next disable, so the rate never changes in the middle of a frame. Channel 0 is the transmit clock and channel 1 is the receive clock. Both take the same encoding.

Top module: `sck_scaler`

## Requirements
- R1: After reset, every SCK output equals the idle level and both strobes of every channel are low.
- R2: With the prescale field (bits 12:8) at zero and an exponent code e of 0 to 4 in bits 2:0, the SCK period is 2^(e+1) module clocks. Each half-period lasts 2^e clocks.
- R3: With the prescale field at 0x1F and exponent code e of 0 to 4, a divide by 32 is added, so each half-period lasts 32·2^e clocks (total divide 64 to 1024).
- R4: With prescale field zero and exponent code 7 (bypass), both strobes are high on every enabled cycle. SCK follows the module clock: it is at the non-idle level while the module clock is high and at idle while it is low.
- R5: Any other encoding behaves as the largest divide, a half-period of 512 clocks. This covers exponent codes 5 and 6, prescale values other than 0 and 0x1F, and code 7 with prescale 0x1F.
- R6: In the cycle after the enable is sampled low, SCK is at the idle level and both strobes are low, whatever the phase was.
- R7: The edge at which the enable is first sampled high is enabled edge 1. The first SCK transition happens at enabled edge H, where H is the half-period. It is always a leading edge.
- R8: In divided modes, the leading strobe is high for exactly the one cycle in which SCK has just left idle. The trailing strobe is high for the one cycle in which SCK has just returned to idle. SCK never changes while running without one of them.
- R9: A scale word written while its channel is enabled has no effect until the enable goes low. A word written while disabled applies to the very next enable.
- R10: The write select input picks the channel (0 transmit, 1 receive). Each channel keeps its own scale word, enable and timing.
- R11: The idle level input sets the SCK rest level: 0 gives idle low, 1 gives idle high.
- R12: Bits 15:13 and 7:3 of the scale word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Scale word write strobe |
| wr_sel | input | 1 | Channel selected by the write (0 transmit, 1 receive) |
| wr_data | input | 16 | Scale word |
| sck_en | input | 2 | Per-channel clock enable |
| idle_hi | input | 1 | SCK idle level |
| sck | output | 2 | Per-channel serial clock |
| lead_stb | output | 2 | Per-channel leading-edge strobe |
| trail_stb | output | 2 | Per-channel trailing-edge strobe |

## Verification
The properties assume that the idle level changes only while every channel is disabled, because a change while running would move SCK with no strobe. They also assume that the write select always names an existing channel. The directed tests change the idle level only after dropping all enables and waiting two cycles. They write only to channel 0 or 1, and drive every input on the falling clock edge, so each enable or write is seen cleanly at the next rising edge.

// File: rtl/sck_scaler_pkg.sv
package sck_scaler_pkg;
  localparam int WORD_W   = 16;
  localparam int PRE_LO   = 8;
  localparam int PRE_W    = 5;
  localparam int EXP_W    = 3;
  localparam int EXP_TOP  = 4;
  localparam int BYP_CODE = 7;
  localparam int PRE_LOG2 = 5;
  localparam int DIV_W    = EXP_TOP;

  typedef struct packed {
    logic             bypass;
    logic             pre_on;
    logic [EXP_W-1:0] expo;
  } scale_cfg_t;
endpackage

// File: rtl/sck_scale_decode.sv
module sck_scale_decode
  import sck_scaler_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output scale_cfg_t        cfg
);
  logic [PRE_W-1:0] pre;
  logic [EXP_W-1:0] code;
  logic             pre_off;
  logic             pre_full;
  logic             code_ok;

  assign pre      = word[PRE_LO +: PRE_W];
  assign code     = word[EXP_W-1:0];
  assign pre_off  = (pre == '0);
  assign pre_full = &pre;
  assign code_ok  = (code <= EXP_W'(EXP_TOP));

  always_comb begin
    cfg.bypass = 1'b0;
    cfg.pre_on = 1'b1;
    cfg.expo   = EXP_W'(EXP_TOP);
    if (pre_off && code == EXP_W'(BYP_CODE)) begin
      cfg.bypass = 1'b1;
      cfg.pre_on = 1'b0;
      cfg.expo   = '0;
    end else if (code_ok && (pre_off || pre_full)) begin
      cfg.pre_on = pre_full;
      cfg.expo   = code;
    end
  end
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int LOG2 = sck_scaler_pkg::PRE_LOG2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pre_on,
  output logic tick
);
  logic [LOG2-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || !en) pc <= '0;
    else            pc <= pc + 1'b1;
  end

  assign tick = !pre_on || (&pc);
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen
  import sck_scaler_pkg::*;
#(
  parameter int CW = DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             idle,
  input  logic             bypass,
  input  logic [EXP_W-1:0] expo,
  input  logic             tick,
  output logic             sck,
  output logic             lead,
  output logic             trail
);
  logic [CW-1:0] dc;
  logic [CW-1:0] lim;
  logic          sck_q;
  logic          byp_q;

  assign lim = ~({CW{1'b1}} << expo);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      dc    <= '0;
      sck_q <= idle;
      byp_q <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (bypass) begin
      dc    <= '0;
      sck_q <= idle;
      byp_q <= 1'b1;
      lead  <= 1'b1;
      trail <= 1'b1;
    end else begin
      byp_q <= 1'b0;
      lead  <= 1'b0;
      trail <= 1'b0;
      if (tick) begin
        if (dc == lim) begin
          dc    <= '0;
          sck_q <= ~sck_q;
          if (sck_q == idle) lead  <= 1'b1;
          else               trail <= 1'b1;
        end else begin
          dc <= dc + 1'b1;
        end
      end
    end
  end

  assign sck = byp_q ? (clk ^ idle) : sck_q;
endmodule

// File: rtl/sck_scaler.sv
module sck_scaler
  import sck_scaler_pkg::*;
#(
  parameter int                NUM_CH   = 2,
  parameter logic [WORD_W-1:0] RST_WORD = '0,
  localparam int               SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] sck_en,
  input  logic              idle_hi,
  output logic [NUM_CH-1:0] sck,
  output logic [NUM_CH-1:0] lead_stb,
  output logic [NUM_CH-1:0] trail_stb
);
  logic [NUM_CH*WORD_W-1:0] act_flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] pend;
    logic [WORD_W-1:0] act;
    logic              hit;
    scale_cfg_t        cfg;
    logic              tick;

    assign hit = wr_en && (wr_sel == SEL_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend <= RST_WORD;
        act  <= RST_WORD;
      end else begin
        if (hit) pend <= wr_data;
        if (!sck_en[c]) act <= hit ? wr_data : pend;
      end
    end

    assign act_flat[c*WORD_W +: WORD_W] = act;

    sck_scale_decode u_dec (
      .word (act),
      .cfg  (cfg)
    );

    sck_prescaler #(.LOG2(PRE_LOG2)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .en     (sck_en[c]),
      .pre_on (cfg.pre_on),
      .tick   (tick)
    );

    sck_edge_gen #(.CW(DIV_W)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .en     (sck_en[c]),
      .idle   (idle_hi),
      .bypass (cfg.bypass),
      .expo   (cfg.expo),
      .tick   (tick),
      .sck    (sck[c]),
      .lead   (lead_stb[c]),
      .trail  (trail_stb[c])
    );
  end
endmodule

// File: rtl/sck_scaler_chk.sv
module sck_scaler_chk #(
  parameter int NUM_CH = 2,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        sck_en,
  input logic                     idle_hi,
  input logic [NUM_CH-1:0]        sck,
  input logic [NUM_CH-1:0]        lead_stb,
  input logic [NUM_CH-1:0]        trail_stb,
  input logic [NUM_CH*WORD_W-1:0] act_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      !sck_en[c] |=> (sck[c] == $past(idle_hi) && !lead_stb[c] && !trail_stb[c]));

    // R8
    lead_level_chk: assert property (@(posedge clk) disable iff (rst)
      (lead_stb[c] && !trail_stb[c]) |-> (sck[c] != idle_hi));

    // R8
    trail_level_chk: assert property (@(posedge clk) disable iff (rst)
      (trail_stb[c] && !lead_stb[c]) |-> (sck[c] == idle_hi));

    // R8
    lead_single_chk: assert property (@(posedge clk) disable iff (rst)
      (lead_stb[c] && !trail_stb[c]) |=> !lead_stb[c]);

    // R8
    edge_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(sck_en[c]) && sck[c] != $past(sck[c])) |-> (lead_stb[c] || trail_stb[c]));

    // R9
    scale_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $past(sck_en[c]) |-> $stable(act_flat[c*WORD_W +: WORD_W]));
  end
endmodule

bind sck_scaler sck_scaler_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sck_en    (sck_en),
  .idle_hi   (idle_hi),
  .sck       (sck),
  .lead_stb  (lead_stb),
  .trail_stb (trail_stb),
  .act_flat  (act_flat)
);

// File: tb/sck_scaler_test.sv
module sck_scaler_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  sck_en = '0;
  logic        idle_hi = 1'b0;
  logic [1:0]  sck;
  logic [1:0]  lead_stb;
  logic [1:0]  trail_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sck_scaler uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sck_en(sck_en), .idle_hi(idle_hi), .sck(sck), .lead_stb(lead_stb),
    .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // enable a channel, find strobe times, then disable it again
  task automatic run_measure(input int ch, input int half, input string req);
    int fl = 0, ft = 0, sl = 0;
    logic lvl = 1'b0, tlvl = 1'b0;
    @(negedge clk);
    sck_en[ch] = 1'b1;
    for (int n = 1; n <= 3*half + 2; n++) begin
      @(posedge clk); @(negedge clk);
      if (lead_stb[ch] && fl == 0) begin fl = n; lvl = sck[ch]; end
      else if (lead_stb[ch] && sl == 0) sl = n;
      if (trail_stb[ch] && ft == 0) begin ft = n; tlvl = sck[ch]; end
    end
    sck_en[ch] = 1'b0;
    check(fl == half, req, "first leading edge cycle (R7)", fl, half);
    check(ft == 2*half, req, "first trailing edge cycle (R8)", ft, 2*half);
    check(sl == 3*half, req, "second leading edge cycle", sl, 3*half);
    check(lvl == ~idle_hi, req, "sck level at leading edge", int'(lvl), int'(~idle_hi));
    check(tlvl == idle_hi, req, "sck level at trailing edge", int'(tlvl), int'(idle_hi));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(sck == 2'b00, "R1", "sck after reset", int'(sck), 0);
    check(lead_stb == 2'b00 && trail_stb == 2'b00, "R1", "strobes after reset",
          int'({lead_stb, trail_stb}), 0);
  endtask

  task automatic t_exponent;
    for (int e = 0; e <= 4; e++) begin
      wr(0, 16'(e));
      run_measure(0, 1 << e, "R2");
    end
  endtask

  task automatic t_prescale;
    for (int e = 0; e <= 4; e++) begin
      wr(0, 16'h1F00 | 16'(e));
      run_measure(0, 32 << e, "R3");
    end
  endtask

  task automatic t_bypass;
    wr(0, 16'h0007);
    @(negedge clk);
    sck_en[0] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(sck[0] == 1'b1, "R4", "sck while clock high", int'(sck[0]), 1);
      @(negedge clk);
      check(sck[0] == 1'b0, "R4", "sck while clock low", int'(sck[0]), 0);
      check(lead_stb[0] && trail_stb[0], "R4", "both strobes each cycle",
            int'({lead_stb[0], trail_stb[0]}), 3);
    end
    sck_en[0] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_unlisted;
    wr(0, 16'h0005); run_measure(0, 512, "R5");
    wr(0, 16'h0006); run_measure(0, 512, "R5");
    wr(0, 16'h0A01); run_measure(0, 512, "R5");
    wr(0, 16'h1F07); run_measure(0, 512, "R5");
  endtask

  task automatic t_ignored;
    wr(0, 16'hE0F9);
    run_measure(0, 2, "R12");
  endtask

  task automatic t_disable;
    int seen = 0;
    wr(0, 16'h0002);
    @(negedge clk);
    sck_en[0] = 1'b1;
    for (int n = 0; n < 20 && !lead_stb[0]; n++) begin
      @(posedge clk); @(negedge clk);
    end
    check(sck[0] == 1'b1, "R6", "sck active before disable", int'(sck[0]), 1);
    sck_en[0] = 1'b0;
    @(negedge clk);
    check(sck[0] == 1'b0, "R6", "sck idle one cycle after disable", int'(sck[0]), 0);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (lead_stb[0] || trail_stb[0] || sck[0]) seen++;
    end
    check(seen == 0, "R6", "activity while disabled", seen, 0);
  endtask

  task automatic t_hold;
    int cnt = 0;
    wr(0, 16'h0000);
    @(negedge clk);
    sck_en[0] = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0002;
    @(negedge clk);
    wr_en = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (lead_stb[0] || trail_stb[0]) cnt++;
    end
    check(cnt == 6, "R9", "old rate kept while enabled", cnt, 6);
    sck_en[0] = 1'b0;
    repeat (2) @(negedge clk);
    run_measure(0, 4, "R9");
  endtask

  task automatic t_channels;
    int act1 = 0;
    wr(0, 16'h0001);
    wr(1, 16'h0003);
    @(negedge clk);
    sck_en[0] = 1'b1;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (lead_stb[1] || trail_stb[1] || sck[1]) act1++;
    end
    sck_en[0] = 1'b0;
    check(act1 == 0, "R10", "receive channel quiet while only transmit runs", act1, 0);
    repeat (2) @(negedge clk);
    run_measure(0, 2, "R10");
    run_measure(1, 8, "R10");
  endtask

  task automatic t_idle_high;
    @(negedge clk);
    idle_hi = 1'b1;
    repeat (2) @(negedge clk);
    check(sck == 2'b11, "R11", "idle high level", int'(sck), 3);
    wr(1, 16'h0001);
    run_measure(1, 2, "R11");
    idle_hi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exponent();
    t_prescale();
    t_bypass();
    t_unlisted();
    t_ignored();
    t_disable();
    t_hold();
    t_channels();
    t_idle_high();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule